// File: doc/BRIEF.md
# Two-Channel Bus-Master Disk DMA Register Bank

This block is the register bank of a two-channel bus-master disk DMA engine. It decodes a 16-byte register window, eight bytes per channel. Each channel has a command byte, a status byte, a timing byte and a 32-bit descriptor-table pointer. A mode byte is shared by both channels: it records which channel has an interrupt request pending and which channel has its interrupt blocked. The block drives one level-sensitive interrupt output from that byte.

Software starts a channel by setting the start bit in its command byte. The bank then marks the channel busy and sends a one-clock start pulse to the data mover. Clearing the start bit sends a one-clock cancel pulse. The data mover reports the end of a transfer with a done pulse or a fault pulse. Each of these clears the busy flag and latches a status flag, which software clears by writing 1 to it.

The bus carries a byte address and four byte enables. Address bits 3:2 select a 32-bit word. Bit 3 picks the channel, and bit 2 picks the control word (0) or the pointer word (1). Byte lane n of a word is byte offset n within it. Read data is combinational from the registers and has no side effects.

Top module: `busdma_regfile`

## Requirements
- R1: After synchronous reset every register reads as zero. Both pulse outputs and the interrupt output are low.
- R2: Byte offset = address[3:0]: offsets 0-7 belong to channel 0 and 8-15 to channel 1. In a channel's control word, lane 0 is command, lane 1 is the shared mode byte, lane 2 is status and lane 3 is timing. Lanes 0-3 of the pointer word are pointer bytes 0-3. Address bits 1:0 are ignored.
- R3: A command write stores the written byte ANDed with 0x09. Bit 0 is the start bit.
- R4: A command write with bit 0 set while status bit 0 (busy) is clear sets busy, and raises that channel's start pulse for the single cycle after the write. While busy is set, such a write sends no pulse.
- R5: A command write with bit 0 clear clears busy and raises that channel's cancel pulse for the single cycle after the write.
- R6: A done pulse on a busy channel clears busy and sets status bit 2. A fault pulse clears busy and sets status bit 1. An event in the same cycle as a write-1-to-clear of its flag leaves the flag set.
- R7: A status write loads bits 6:5 from the data, clears bits 1 and 2 where the data holds a 1, and leaves bit 0 unchanged. Status bits 7, 4 and 3 read as zero.
- R8: Pointer writes replace only the enabled byte lanes, and pointer bits 1:0 always read as zero.
- R9: Mode bits 2 and 3 copy the channel 0 and channel 1 interrupt-request inputs one cycle later. A write to the mode byte, through either channel's window, changes only bits 5 and 4 (the block flags for channels 1 and 0). All other mode bits read as zero.
- R10: The interrupt output equals (mode bit 2 AND NOT bit 4) OR (mode bit 3 AND NOT bit 5), taken from the current register values.
- R11: Each channel's timing byte is written and read back only through that channel's own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 32 | Combinational read data |
| irq_req | input | 2 | Per-channel interrupt-request levels |
| xfer_done | input | 2 | Per-channel transfer-complete pulses |
| xfer_fault | input | 2 | Per-channel transfer-error pulses |
| start_pulse | output | 2 | One-cycle start request per channel |
| cancel_pulse | output | 2 | One-cycle cancel request per channel |
| irq_out | output | 1 | Combined interrupt level |

## Verification
The assertions assume that the data mover sends done or fault only while its channel is busy. They also assume that one bus write arrives per cycle, which follows from the single strobe. The random stimulus enforces the first rule by drawing done and fault pulses only for channels that the bench's own model holds busy. Done and fault are never raised together on the same channel. The directed phase covers start while busy, a write-1-to-clear on idle flags, masked mode writes and partial pointer writes.

// File: rtl/busdma_pkg.sv
package busdma_pkg;
    localparam int CH_N    = 2;
    localparam int LANE_N  = 4;
    localparam int BYTE_W  = 8;
    localparam int DATA_W  = LANE_N * BYTE_W;
    localparam int ADDR_W  = 4;

    localparam int LANE_CMD  = 0;
    localparam int LANE_MODE = 1;
    localparam int LANE_STAT = 2;
    localparam int LANE_TIME = 3;

    localparam logic [BYTE_W-1:0] CMD_KEEP = 8'h09;
    localparam logic [BYTE_W-1:0] PTR_LOW0 = 8'hFC;

    localparam int MODE_PEND_LSB = 2;
    localparam int MODE_BLK_LSB  = 4;

    typedef enum logic {
        WORD_CTL = 1'b0,
        WORD_PTR = 1'b1
    } word_e;

    typedef struct packed {
        logic [1:0] user;
        logic       irq;
        logic       err;
        logic       busy;
    } stat_t;

    function automatic logic [BYTE_W-1:0] stat_byte(input stat_t s);
        return {1'b0, s.user, 2'b00, s.irq, s.err, s.busy};
    endfunction

    function automatic logic [BYTE_W-1:0] lane_of(input logic [DATA_W-1:0] w, input int n);
        return w[n*BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/busdma_chan.sv
module busdma_chan
    import busdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic              wr_ptr,
    input  logic [LANE_N-1:0] be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              fault,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] stat_q,
    output logic [BYTE_W-1:0] time_q,
    output logic [DATA_W-1:0] ptr_q,
    output logic              busy,
    output logic              start_p,
    output logic              cancel_p
);
    stat_t             st;
    logic [BYTE_W-1:0] cmd_r;
    logic [BYTE_W-1:0] time_r;
    logic [DATA_W-1:0] ptr_r;
    logic [BYTE_W-1:0] cmd_b;
    logic [BYTE_W-1:0] stat_b;
    logic [BYTE_W-1:0] time_b;

    assign cmd_b  = lane_of(wdata, LANE_CMD);
    assign stat_b = lane_of(wdata, LANE_STAT);
    assign time_b = lane_of(wdata, LANE_TIME);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            cmd_r    <= '0;
            time_r   <= '0;
            ptr_r    <= '0;
            start_p  <= 1'b0;
            cancel_p <= 1'b0;
        end else begin
            start_p  <= 1'b0;
            cancel_p <= 1'b0;
            // software write-1-to-clear first, hardware events override
            if (wr_ctl && be[LANE_STAT]) begin
                st.user <= stat_b[6:5];
                if (stat_b[1]) st.err <= 1'b0;
                if (stat_b[2]) st.irq <= 1'b0;
            end
            if (done || fault) st.busy <= 1'b0;
            if (done)  st.irq <= 1'b1;
            if (fault) st.err <= 1'b1;
            if (wr_ctl && be[LANE_TIME]) time_r <= time_b;
            if (wr_ctl && be[LANE_CMD]) begin
                cmd_r <= cmd_b & CMD_KEEP;
                if (cmd_b[0]) begin
                    if (!st.busy) begin
                        st.busy <= 1'b1;
                        start_p <= 1'b1;
                    end
                end else begin
                    st.busy  <= 1'b0;
                    cancel_p <= 1'b1;
                end
            end
            for (int b = 0; b < LANE_N; b++) begin
                if (wr_ptr && be[b]) begin
                    if (b == 0) ptr_r[b*BYTE_W +: BYTE_W] <= lane_of(wdata, b) & PTR_LOW0;
                    else        ptr_r[b*BYTE_W +: BYTE_W] <= lane_of(wdata, b);
                end
            end
        end
    end

    assign cmd_q  = cmd_r;
    assign stat_q = stat_byte(st);
    assign time_q = time_r;
    assign ptr_q  = ptr_r;
    assign busy   = st.busy;
endmodule

// File: rtl/busdma_mode.sv
module busdma_mode
    import busdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CH_N-1:0]   irq_req,
    input  logic              wr_mode,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] mode_q,
    output logic [CH_N-1:0]   blk,
    output logic              irq_out
);
    logic [CH_N-1:0] pend_r;
    logic [CH_N-1:0] blk_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_r <= '0;
            blk_r  <= '0;
        end else begin
            pend_r <= irq_req;
            if (wr_mode) blk_r <= wr_byte[MODE_BLK_LSB +: CH_N];
        end
    end

    always_comb begin
        mode_q = '0;
        mode_q[MODE_PEND_LSB +: CH_N] = pend_r;
        mode_q[MODE_BLK_LSB  +: CH_N] = blk_r;
    end

    assign blk     = blk_r;
    assign irq_out = |(pend_r & ~blk_r);
endmodule

// File: rtl/busdma_regfile.sv
module busdma_regfile
    import busdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANE_N-1:0] bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CH_N-1:0]   irq_req,
    input  logic [CH_N-1:0]   xfer_done,
    input  logic [CH_N-1:0]   xfer_fault,
    output logic [CH_N-1:0]   start_pulse,
    output logic [CH_N-1:0]   cancel_pulse,
    output logic              irq_out
);
    localparam int CH_BIT   = ADDR_W - 1;
    localparam int KIND_BIT = ADDR_W - 2;

    word_e             kind;
    logic              sel_ch;
    logic [CH_N-1:0]   wr_ctl;
    logic [CH_N-1:0]   wr_ptr;
    logic [CH_N-1:0]   chan_active;
    logic [CH_N-1:0]   mode_blk;
    logic [BYTE_W-1:0] mode_q;
    logic [BYTE_W-1:0] cmd_a  [CH_N];
    logic [BYTE_W-1:0] stat_a [CH_N];
    logic [BYTE_W-1:0] time_a [CH_N];
    logic [DATA_W-1:0] ptr_a  [CH_N];

    assign kind   = word_e'(bus_addr[KIND_BIT]);
    assign sel_ch = bus_addr[CH_BIT];

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        assign wr_ctl[c] = bus_wr && (sel_ch == c[0]) && (kind == WORD_CTL);
        assign wr_ptr[c] = bus_wr && (sel_ch == c[0]) && (kind == WORD_PTR);

        busdma_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_ctl   (wr_ctl[c]),
            .wr_ptr   (wr_ptr[c]),
            .be       (bus_be),
            .wdata    (bus_wdata),
            .done     (xfer_done[c]),
            .fault    (xfer_fault[c]),
            .cmd_q    (cmd_a[c]),
            .stat_q   (stat_a[c]),
            .time_q   (time_a[c]),
            .ptr_q    (ptr_a[c]),
            .busy     (chan_active[c]),
            .start_p  (start_pulse[c]),
            .cancel_p (cancel_pulse[c])
        );
    end

    busdma_mode u_mode (
        .clk     (clk),
        .rst     (rst),
        .irq_req (irq_req),
        .wr_mode ((|wr_ctl) && bus_be[LANE_MODE]),
        .wr_byte (lane_of(bus_wdata, LANE_MODE)),
        .mode_q  (mode_q),
        .blk     (mode_blk),
        .irq_out (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (kind == WORD_PTR) bus_rdata = ptr_a[sel_ch];
            else bus_rdata = {time_a[sel_ch], stat_a[sel_ch], mode_q, cmd_a[sel_ch]};
        end
    end
endmodule

// File: rtl/busdma_regfile_chk.sv
module busdma_regfile_chk
    import busdma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CH_N-1:0]   irq_req,
    input logic [CH_N-1:0]   xfer_done,
    input logic [CH_N-1:0]   xfer_fault,
    input logic [CH_N-1:0]   start_pulse,
    input logic [CH_N-1:0]   cancel_pulse,
    input logic [CH_N-1:0]   act,
    input logic [CH_N-1:0]   blk,
    input logic              irq_out
);
    for (genvar c = 0; c < CH_N; c++) begin : g_c
        a_r4_start_marks_busy: assert property (@(posedge clk) disable iff (rst)
            start_pulse[c] |-> act[c]);
        a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
            start_pulse[c] |=> !start_pulse[c]);
        a_r5_cancel_idle: assert property (@(posedge clk) disable iff (rst)
            cancel_pulse[c] |-> (!act[c] && !start_pulse[c]));
        a_r6_event_ends_busy: assert property (@(posedge clk) disable iff (rst)
            (act[c] && (xfer_done[c] || xfer_fault[c])) |=> !act[c]);
    end

    a_r8_ptr_aligned: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[ADDR_W-2]) |-> (bus_rdata[1:0] == 2'b00));
    a_r10_quiet_without_req: assert property (@(posedge clk) disable iff (rst)
        !$past(|irq_req) |-> !irq_out);
    a_r9_all_blocked: assert property (@(posedge clk) disable iff (rst)
        (&blk) |-> !irq_out);
endmodule

bind busdma_regfile busdma_regfile_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .irq_req      (irq_req),
    .xfer_done    (xfer_done),
    .xfer_fault   (xfer_fault),
    .start_pulse  (start_pulse),
    .cancel_pulse (cancel_pulse),
    .act          (chan_active),
    .blk          (mode_blk),
    .irq_out      (irq_out)
);

// File: tb/test_busdma_regfile.sv
module test_busdma_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_req = '0;
    logic [1:0]  xfer_done = '0;
    logic [1:0]  xfer_fault = '0;
    logic [1:0]  start_pulse;
    logic [1:0]  cancel_pulse;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit [7:0]  m_cmd [2];
    bit        m_busy [2];
    bit        m_err [2];
    bit        m_irqf [2];
    bit [1:0]  m_user [2];
    bit [7:0]  m_time [2];
    bit [31:0] m_ptr [2];
    bit        m_pend [2];
    bit        m_blk [2];
    bit        e_start [2];
    bit        e_cancel [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    busdma_regfile i_busdma_regfile (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .xfer_done(xfer_done),
        .xfer_fault(xfer_fault), .start_pulse(start_pulse),
        .cancel_pulse(cancel_pulse), .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] mode_val();
        return {2'b00, m_blk[1], m_blk[0], m_pend[1], m_pend[0], 2'b00};
    endfunction

    function automatic bit [31:0] exp_word(input logic [3:0] a);
        int c = a[3];
        bit [7:0] s = {1'b0, m_user[c], 2'b00, m_irqf[c], m_err[c], m_busy[c]};
        if (a[2]) return m_ptr[c];
        return {m_time[c], s, mode_val(), m_cmd[c]};
    endfunction

    task automatic check_read(input logic [3:0] a);
        bit [31:0] e = exp_word(a);
        if (a[2]) begin
            chk(bus_rdata == e, "R2 R8 pointer word", bus_rdata, e);
        end else begin
            chk(bus_rdata[7:0]   == e[7:0],   "R2 R3 command",  {24'h0, bus_rdata[7:0]},   {24'h0, e[7:0]});
            chk(bus_rdata[15:8]  == e[15:8],  "R2 R9 mode",     {24'h0, bus_rdata[15:8]},  {24'h0, e[15:8]});
            chk(bus_rdata[23:16] == e[23:16], "R2 R6 R7 status",{24'h0, bus_rdata[23:16]}, {24'h0, e[23:16]});
            chk(bus_rdata[31:24] == e[31:24], "R2 R11 timing",  {24'h0, bus_rdata[31:24]}, {24'h0, e[31:24]});
        end
    endtask

    task automatic model_update(input logic [3:0] a, input logic [3:0] be, input logic [31:0] wd,
                                input logic wr, input logic [1:0] dn, input logic [1:0] ft, input logic [1:0] rq);
        int c = a[3];
        bit old_busy [2];
        for (int k = 0; k < 2; k++) begin
            e_start[k] = 0;
            e_cancel[k] = 0;
            old_busy[k] = m_busy[k];
        end
        if (wr && !a[2]) begin
            if (be[2]) begin
                m_user[c] = wd[22:21];
                if (wd[17]) m_err[c] = 0;
                if (wd[18]) m_irqf[c] = 0;
            end
            if (be[1]) begin
                m_blk[0] = wd[12];
                m_blk[1] = wd[13];
            end
            if (be[3]) m_time[c] = wd[31:24];
        end
        if (wr && a[2]) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) m_ptr[c][b*8 +: 8] = wd[b*8 +: 8];
            m_ptr[c][1:0] = 2'b00;
        end
        for (int k = 0; k < 2; k++) begin
            if (dn[k] || ft[k]) m_busy[k] = 0;
            if (dn[k]) m_irqf[k] = 1;
            if (ft[k]) m_err[k] = 1;
        end
        if (wr && !a[2] && be[0]) begin
            m_cmd[c] = wd[7:0] & 8'h09;
            if (wd[0]) begin
                if (!old_busy[c]) begin
                    m_busy[c] = 1;
                    e_start[c] = 1;
                end
            end else begin
                m_busy[c] = 0;
                e_cancel[c] = 1;
            end
        end
        m_pend[0] = rq[0];
        m_pend[1] = rq[1];
    endtask

    task automatic step(input logic [3:0] a, input logic [3:0] be, input logic [31:0] wd,
                        input logic wr, input logic [1:0] dn, input logic [1:0] ft, input logic [1:0] rq);
        bit e_irq;
        bus_addr = a; bus_be = be; bus_wdata = wd; bus_wr = wr; bus_rd = 1'b1;
        xfer_done = dn; xfer_fault = ft; irq_req = rq;
        #1;
        check_read(a);
        @(posedge clk);
        @(negedge clk);
        model_update(a, be, wd, wr, dn, ft, rq);
        for (int k = 0; k < 2; k++) begin
            chk(start_pulse[k] == e_start[k], "R4 start pulse", {31'h0, start_pulse[k]}, {31'h0, e_start[k]});
            chk(cancel_pulse[k] == e_cancel[k], "R5 cancel pulse", {31'h0, cancel_pulse[k]}, {31'h0, e_cancel[k]});
        end
        e_irq = (m_pend[0] && !m_blk[0]) || (m_pend[1] && !m_blk[1]);
        chk(irq_out == e_irq, "R10 interrupt", {31'h0, irq_out}, {31'h0, e_irq});
    endtask

    task automatic idle(input logic [3:0] a, input logic [1:0] rq);
        step(a, 4'h0, 32'h0, 1'b0, 2'b00, 2'b00, rq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state through the read port and outputs
        for (int w = 0; w < 4; w++) begin
            bus_addr = 4'(w * 4); bus_rd = 1'b1;
            #1;
            chk(bus_rdata == 32'h0, "R1 reset value", bus_rdata, 32'h0);
        end
        chk(start_pulse == 2'b00 && cancel_pulse == 2'b00 && irq_out == 1'b0,
            "R1 outputs after reset", {29'h0, start_pulse, irq_out}, 32'h0);
        @(negedge clk);

        // R3 R4: command masking and start
        step(4'h0, 4'b0001, 32'h0000_00FF, 1, 0, 0, 0);
        idle(4'h0, 0);
        // R4: start while busy is ignored
        step(4'h0, 4'b0001, 32'h0000_0001, 1, 0, 0, 0);
        // R7: status write keeps busy, loads user bits
        step(4'h0, 4'b0100, 32'h00FF_0000, 1, 0, 0, 0);
        idle(4'h0, 0);
        // R6: done clears busy and sets flag
        step(4'h0, 4'b0000, 32'h0, 0, 2'b01, 0, 0);
        idle(4'h0, 0);
        // R7: clear flag by writing 1
        step(4'h0, 4'b0100, 32'h0004_0000, 1, 0, 0, 0);
        idle(4'h0, 0);
        // R6: fault and write-1-to-clear in the same cycle; event wins
        step(4'h8, 4'b0001, 32'h0000_0001, 1, 0, 0, 0);
        step(4'h8, 4'b0100, 32'h0002_0000, 1, 0, 2'b10, 0);
        idle(4'h8, 0);
        // R5: cancel on channel 1
        step(4'h8, 4'b0001, 32'h0000_0000, 1, 0, 0, 0);
        idle(4'h8, 0);
        // R8: partial pointer writes
        step(4'hC, 4'b0001, 32'h0000_00FF, 1, 0, 0, 0);
        idle(4'hC, 0);
        step(4'hC, 4'b1100, 32'hABCD_0000, 1, 0, 0, 0);
        idle(4'hC, 0);
        step(4'h4, 4'b1111, 32'hFFFF_FFFF, 1, 0, 0, 0);
        idle(4'h4, 0);
        step(4'h4, 4'b0010, 32'h0000_1200, 1, 0, 0, 0);
        idle(4'h7, 0);
        // R9 R10: pending follows request, block masks it
        idle(4'h0, 2'b01);
        idle(4'h0, 2'b01);
        step(4'h9, 4'b0010, 32'h0000_1000, 1, 0, 0, 2'b01);
        idle(4'h0, 2'b11);
        step(4'h0, 4'b0010, 32'h0000_FF00, 1, 0, 0, 2'b11);
        idle(4'h1, 2'b11);
        step(4'h0, 4'b0010, 32'h0000_0000, 1, 0, 0, 2'b10);
        idle(4'h2, 0);
        // R11: timing bytes per channel
        step(4'h0, 4'b1000, 32'h5A00_0000, 1, 0, 0, 0);
        step(4'hB, 4'b1000, 32'hA500_0000, 1, 0, 0, 0);
        idle(4'h3, 0);
        idle(4'hA, 0);

        // random phase; done/fault only while model holds channel busy
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] dn = 0;
            logic [1:0] ft = 0;
            for (int k = 0; k < 2; k++) begin
                if (m_busy[k] && ($urandom % 6 == 0)) dn[k] = 1'b1;
                else if (m_busy[k] && ($urandom % 12 == 0)) ft[k] = 1'b1;
            end
            step(4'($urandom), 4'($urandom), $urandom, 1'($urandom), dn, ft, 2'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule